// File: doc/BRIEF.md
# Indirect GPIO Port Configuration Register File

This block holds the configuration for eight 8-bit GPIO ports. Software reaches all of it through a small register window. A port-select register picks one port, and every configuration register in the window then reads and writes that port only. The registers per port are an interrupt mask, a PWM-select mask, an input-inversion mask, a direction mask, an output-data register and seven drive-mode registers.

The seven drive-mode registers work as a per-pin one-hot set. Writing a 1 to a pin's bit in one of them makes that mode the pin's mode, and the same bit is then clear in the other six. The most recent write therefore wins. Reading a drive-mode register returns the mode in effect for each pin, not the raw data last written.

Per pin, the block drives out a one-hot drive mode, a direction bit and an output level. It also drives the interrupt mask and the input level after inversion. The output level is taken either from the output-data register or from the output-data bit gated with an external PWM level. The bus front end, the PWM generators and the pads are outside the block. The block has no state machine: every register updates in the cycle its write is presented.

Top module: `pcfg_regfile`

## Requirements
- R1: After reset, the following values hold for every pin of every port:
  - port select is 0;
  - mask, PWM-select, inversion and output-data are 0;
  - direction is 1;
  - drive mode is resistive pull-up.
- R2: A write of a value 0 to 7 to address 0 selects that port. From the next cycle, address 0 reads back that value.
- R3: A write to address 0 of a value above 7 is ignored, and the previous selection is kept.
- R4: The following addresses read and write the selected port only, and the other ports keep their values:
  - 1: interrupt mask;
  - 2: PWM select;
  - 3: inversion;
  - 4: direction;
  - 12: output data.
- R5: `pin_dir` bit p*8+b equals the direction bit b of port p. A 1 means input and a 0 means output. `int_mask` bit p*8+b equals the mask bit b of port p.
- R6: A write to drive address 5+m sets mode m for each pin of the selected port whose data bit is 1. The mode order is:
  - m=0: pull-up;
  - m=1: pull-down;
  - m=2: open-drain high;
  - m=3: open-drain low;
  - m=4: strong fast;
  - m=5: strong slow;
  - m=6: high impedance.
  `drv_mode` bit (p*8+b)*7+m is the one-hot flag of mode m for pin b of port p, and exactly one flag per pin is set at all times.
- R7: Data bits that are 0 in a drive-mode write leave the mode of those pins unchanged.
- R8: A read of drive address 5+m returns, in bit b, 1 exactly when pin b of the selected port is currently in mode m.
- R9: The value of `pin_out` bit i depends on PWM select:
  - when PWM select is 0, it equals output-data bit i;
  - when PWM select is 1, it equals output-data bit i AND `pwm_in` bit i.
- R10: `in_level` bit i equals `pin_in` bit i XOR inversion bit i.
- R11: Addresses 13 to 15 read 0. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address in the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| pwm_in | input | 64 | PWM level per pin |
| pin_in | input | 64 | Raw pad input level per pin |
| pin_out | output | 64 | Output level per pin |
| pin_dir | output | 64 | Direction per pin, 1 = input |
| int_mask | output | 64 | Interrupt mask per pin |
| in_level | output | 64 | Input level after inversion |
| drv_mode | output | 448 | One-hot drive mode, 7 bits per pin |

## Verification
A write presented while `wr_en` is high takes effect at the next rising edge. From then on, `pin_dir`, `int_mask`, `drv_mode` and `rdata` show the new value, with no further register in the path. `pin_out` and `in_level` also follow `pwm_in` and `pin_in` in the same cycle, without a clock.

The bench drives every input at a falling edge. It holds a write for exactly one rising edge and compares outputs at the following falling edge. For reads it compares `rdata` one time unit after setting `addr` at a falling edge. Each comparison is against a model of the address map kept in the bench.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
    localparam int NPORTS = 8;
    localparam int PW     = 8;
    localparam int NMODES = 7;
    localparam int AW     = 4;
    localparam int SW     = $clog2(NPORTS);
    localparam int MW     = $clog2(NMODES);

    localparam logic [AW-1:0] A_SEL  = 4'd0;
    localparam logic [AW-1:0] A_MASK = 4'd1;
    localparam logic [AW-1:0] A_PWM  = 4'd2;
    localparam logic [AW-1:0] A_INV  = 4'd3;
    localparam logic [AW-1:0] A_DIR  = 4'd4;
    localparam logic [AW-1:0] A_DRV0 = 4'd5;
    localparam logic [AW-1:0] A_DRV6 = 4'd11;
    localparam logic [AW-1:0] A_OUT  = 4'd12;

    typedef enum logic [2:0] {
        F_MASK = 3'd0,
        F_PWM  = 3'd1,
        F_INV  = 3'd2,
        F_DIR  = 3'd3,
        F_OUT  = 3'd4,
        F_NONE = 3'd7
    } field_e;
endpackage

// File: rtl/pcfg_port_bank.sv
module pcfg_port_bank
    import pcfg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  field_e       fld,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_q,
    output logic [W-1:0] pwm_q,
    output logic [W-1:0] inv_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] out_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            pwm_q  <= '0;
            inv_q  <= '0;
            dir_q  <= '1;
            out_q  <= '0;
        end else if (wr_en) begin
            unique case (fld)
                F_MASK:  mask_q <= wdata;
                F_PWM:   pwm_q  <= wdata;
                F_INV:   inv_q  <= wdata;
                F_DIR:   dir_q  <= wdata;
                F_OUT:   out_q  <= wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pcfg_drv_bank.sv
module pcfg_drv_bank #(
    parameter int W  = 8,
    parameter int NM = 7,
    localparam int MSW = $clog2(NM)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [MSW-1:0]  msel,
    input  logic [W-1:0]    wdata,
    output logic [W*NM-1:0] mode_q
);
    logic [NM-1:0] new_mode;
    assign new_mode = NM'(1) << msel;

    for (genvar b = 0; b < W; b++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mode_q[b*NM +: NM] <= NM'(1);
            end else if (wr_en && wdata[b]) begin
                mode_q[b*NM +: NM] <= new_mode;
            end
        end
    end
endmodule

// File: rtl/pcfg_pin_mux.sv
module pcfg_pin_mux #(
    parameter int W = 8
) (
    input  logic [W-1:0] out_v,
    input  logic [W-1:0] pwm_sel,
    input  logic [W-1:0] pwm_lvl,
    output logic [W-1:0] pin_out
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_comb begin
            if (pwm_sel[b]) pin_out[b] = out_v[b] & pwm_lvl[b];
            else            pin_out[b] = out_v[b];
        end
    end
endmodule

// File: rtl/pcfg_regfile.sv
module pcfg_regfile
    import pcfg_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [AW-1:0]              addr,
    input  logic [PW-1:0]              wdata,
    output logic [PW-1:0]              rdata,
    input  logic [NPORTS*PW-1:0]       pwm_in,
    input  logic [NPORTS*PW-1:0]       pin_in,
    output logic [NPORTS*PW-1:0]       pin_out,
    output logic [NPORTS*PW-1:0]       pin_dir,
    output logic [NPORTS*PW-1:0]       int_mask,
    output logic [NPORTS*PW-1:0]       in_level,
    output logic [NPORTS*PW*NMODES-1:0] drv_mode
);
    localparam int PB = PW * NMODES;

    logic [SW-1:0] sel_q;
    logic          sel_ok;
    field_e        fld;
    logic          is_drv;
    logic [AW-1:0] drv_off;
    logic [MW-1:0] msel;

    logic [PW-1:0] mask_a [NPORTS];
    logic [PW-1:0] pwm_a  [NPORTS];
    logic [PW-1:0] inv_a  [NPORTS];
    logic [PW-1:0] dir_a  [NPORTS];
    logic [PW-1:0] out_a  [NPORTS];
    logic [PB-1:0] mode_a [NPORTS];

    assign sel_ok = (wdata >> SW) == '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (wr_en && addr == A_SEL && sel_ok) begin
            sel_q <= wdata[SW-1:0];
        end
    end

    always_comb begin
        case (addr)
            A_MASK:  fld = F_MASK;
            A_PWM:   fld = F_PWM;
            A_INV:   fld = F_INV;
            A_DIR:   fld = F_DIR;
            A_OUT:   fld = F_OUT;
            default: fld = F_NONE;
        endcase
    end

    assign is_drv  = (addr >= A_DRV0) && (addr <= A_DRV6);
    assign drv_off = addr - A_DRV0;
    assign msel    = drv_off[MW-1:0];

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic hit;
        assign hit = wr_en && (sel_q == SW'(p));

        pcfg_port_bank #(.W(PW)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (hit && fld != F_NONE),
            .fld    (fld),
            .wdata  (wdata),
            .mask_q (mask_a[p]),
            .pwm_q  (pwm_a[p]),
            .inv_q  (inv_a[p]),
            .dir_q  (dir_a[p]),
            .out_q  (out_a[p])
        );

        pcfg_drv_bank #(.W(PW), .NM(NMODES)) u_drv (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (hit && is_drv),
            .msel   (msel),
            .wdata  (wdata),
            .mode_q (mode_a[p])
        );

        pcfg_pin_mux #(.W(PW)) u_mux (
            .out_v   (out_a[p]),
            .pwm_sel (pwm_a[p]),
            .pwm_lvl (pwm_in[p*PW +: PW]),
            .pin_out (pin_out[p*PW +: PW])
        );

        assign pin_dir [p*PW +: PW] = dir_a[p];
        assign int_mask[p*PW +: PW] = mask_a[p];
        assign in_level[p*PW +: PW] = pin_in[p*PW +: PW] ^ inv_a[p];
        assign drv_mode[p*PB +: PB] = mode_a[p];
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_SEL:  rdata = PW'(sel_q);
            A_MASK: rdata = mask_a[sel_q];
            A_PWM:  rdata = pwm_a[sel_q];
            A_INV:  rdata = inv_a[sel_q];
            A_DIR:  rdata = dir_a[sel_q];
            A_OUT:  rdata = out_a[sel_q];
            default: begin
                if (is_drv) begin
                    for (int b = 0; b < PW; b++) begin
                        rdata[b] = mode_a[sel_q][b*NMODES + int'(msel)];
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/pcfg_regfile_chk.sv
module pcfg_regfile_chk
    import pcfg_pkg::*;
(
    input logic                        clk,
    input logic                        rst_n,
    input logic                        wr_en,
    input logic [AW-1:0]               addr,
    input logic [PW-1:0]               wdata,
    input logic [SW-1:0]               sel_q,
    input logic [NPORTS*PW-1:0]        pin_dir,
    input logic [NPORTS*PW*NMODES-1:0] drv_mode
);
    for (genvar i = 0; i < NPORTS*PW; i++) begin : g_oh
        // R6
        drv_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(drv_mode[i*NMODES +: NMODES]) == 1);
    end

    // R2
    sel_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_SEL && wdata[PW-1:SW] == '0) |=> sel_q == $past(wdata[SW-1:0]));

    // R3
    sel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_SEL && wdata[PW-1:SW] != '0) |=> $stable(sel_q));

    // R7
    drv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr >= A_DRV0 && addr <= A_DRV6 && wdata == '0) |=> $stable(drv_mode));

    // R11
    unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr > A_OUT) |=> ($stable(drv_mode) && $stable(pin_dir) && $stable(sel_q)));
endmodule

bind pcfg_regfile pcfg_regfile_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .sel_q    (sel_q),
    .pin_dir  (pin_dir),
    .drv_mode (drv_mode)
);

// File: tb/pcfg_regfile_tb.sv
module pcfg_regfile_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [3:0]   addr = '0;
    logic [7:0]   wdata = '0;
    logic [7:0]   rdata;
    logic [63:0]  pwm_in = '0;
    logic [63:0]  pin_in = '0;
    logic [63:0]  pin_out, pin_dir, int_mask, in_level;
    logic [447:0] drv_mode;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    int         m_sel;
    logic [7:0] m_cfg [5][8];
    int         m_mode [8][8];

    always #4 clk = ~clk;

    pcfg_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pwm_in(pwm_in), .pin_in(pin_in), .pin_out(pin_out),
        .pin_dir(pin_dir), .int_mask(int_mask), .in_level(in_level),
        .drv_mode(drv_mode)
    );

    task automatic chk(string tag, logic [447:0] got, logic [447:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        m_sel = 0;
        for (int p = 0; p < 8; p++) begin
            for (int f = 0; f < 5; f++) m_cfg[f][p] = (f == 3) ? 8'hFF : 8'h00;
            for (int b = 0; b < 8; b++) m_mode[p][b] = 0;
        end
    endtask

    task automatic model_wr(int a, logic [7:0] d);
        if (a == 0) begin
            if (d < 8) m_sel = d;
        end else if (a >= 1 && a <= 4) begin
            m_cfg[a-1][m_sel] = d;
        end else if (a == 12) begin
            m_cfg[4][m_sel] = d;
        end else if (a >= 5 && a <= 11) begin
            for (int b = 0; b < 8; b++) if (d[b]) m_mode[m_sel][b] = a - 5;
        end
    endtask

    function automatic logic [7:0] exp_rd(int a);
        logic [7:0] v = '0;
        if (a == 0) v = 8'(m_sel);
        else if (a >= 1 && a <= 4) v = m_cfg[a-1][m_sel];
        else if (a == 12) v = m_cfg[4][m_sel];
        else if (a >= 5 && a <= 11)
            for (int b = 0; b < 8; b++) v[b] = (m_mode[m_sel][b] == a - 5);
        return v;
    endfunction

    task automatic wr(int a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 4'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_wr(a, d);
    endtask

    task automatic rd_chk(string tag, int a);
        @(negedge clk);
        addr = 4'(a);
        #1;
        chk(tag, 448'(rdata), 448'(exp_rd(a)));
    endtask

    task automatic check_all(string tag);
        logic [63:0]  e_dir, e_mask, e_lvl, e_out;
        logic [447:0] e_drv = '0;
        for (int p = 0; p < 8; p++) begin
            for (int b = 0; b < 8; b++) begin
                int i = p*8 + b;
                e_mask[i] = m_cfg[0][p][b];
                e_dir[i]  = m_cfg[3][p][b];
                e_lvl[i]  = pin_in[i] ^ m_cfg[2][p][b];
                e_out[i]  = m_cfg[1][p][b] ? (m_cfg[4][p][b] & pwm_in[i]) : m_cfg[4][p][b];
                e_drv[i*7 + m_mode[p][b]] = 1'b1;
            end
        end
        #1;
        chk({tag, " dir R5"},   448'(pin_dir),  448'(e_dir));
        chk({tag, " mask R5"},  448'(int_mask), 448'(e_mask));
        chk({tag, " level R10"}, 448'(in_level), 448'(e_lvl));
        chk({tag, " out R9"},   448'(pin_out),  448'(e_out));
        chk({tag, " mode R6"},  drv_mode,       e_drv);
    endtask

    task automatic t_reset();
        check_all("R1 reset");
        rd_chk("R1 reset select", 0);
        rd_chk("R1 reset pull-up read", 5);
        rd_chk("R1 reset direction read", 4);
    endtask

    task automatic t_select();
        wr(0, 8'd5);
        rd_chk("R2 select 5", 0);
        wr(0, 8'd7);
        rd_chk("R2 select 7", 0);
        wr(0, 8'd0);
        rd_chk("R2 select 0", 0);
    endtask

    task automatic t_bad_select();
        wr(0, 8'd5);
        wr(0, 8'd8);
        rd_chk("R3 select 8 ignored", 0);
        wr(0, 8'hFF);
        rd_chk("R3 select FF ignored", 0);
    endtask

    task automatic t_cfg();
        wr(0, 8'd2);
        wr(1, 8'hC3); wr(2, 8'h11); wr(3, 8'h0F); wr(4, 8'h5A); wr(12, 8'h99);
        wr(0, 8'd6);
        wr(1, 8'h3C); wr(4, 8'h00); wr(12, 8'hFF);
        for (int a = 1; a <= 4; a++) rd_chk("R4 port 6 field", a);
        rd_chk("R4 port 6 out", 12);
        wr(0, 8'd2);
        for (int a = 1; a <= 4; a++) rd_chk("R4 port 2 field", a);
        rd_chk("R4 port 2 out", 12);
        check_all("R4 R5 cfg");
    endtask

    task automatic t_drive();
        wr(0, 8'd3);
        wr(9, 8'h0F);
        wr(11, 8'h3C);
        wr(6, 8'h80);
        for (int a = 5; a <= 11; a++) rd_chk("R8 resolved read", a);
        check_all("R6 last write wins");
        wr(0, 8'd0);
        wr(7, 8'h01);
        wr(8, 8'h02);
        wr(10, 8'h04);
        rd_chk("R8 port 0 mode 3", 8);
        check_all("R6 port 0 modes");
    endtask

    task automatic t_zero();
        wr(0, 8'd3);
        for (int a = 5; a <= 11; a++) wr(a, 8'h00);
        rd_chk("R7 zero write keeps hiz", 11);
        rd_chk("R7 zero write keeps fast", 9);
        check_all("R7 zero write");
    endtask

    task automatic t_pwm();
        wr(0, 8'd1);
        wr(12, 8'hAA);
        wr(2, 8'hF0);
        pwm_in = 64'h0;
        check_all("R9 pwm low");
        pwm_in = 64'hFFFF_FFFF_FFFF_FFFF;
        check_all("R9 pwm high");
        pwm_in = 64'h0000_0000_0000_6500;
        check_all("R9 pwm mixed");
    endtask

    task automatic t_inv();
        wr(0, 8'd4);
        wr(3, 8'h5A);
        pin_in = 64'h0;
        check_all("R10 inv zeros");
        pin_in = 64'hF0F0_1234_8765_00FF;
        check_all("R10 inv pattern");
    endtask

    task automatic t_unmapped();
        wr(13, 8'hFF);
        wr(14, 8'h07);
        wr(15, 8'h81);
        rd_chk("R11 addr 13 reads 0", 13);
        rd_chk("R11 addr 15 reads 0", 15);
        rd_chk("R11 select kept", 0);
        check_all("R11 no state change");
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_select();
        t_bad_select();
        t_cfg();
        t_drive();
        t_zero();
        t_pwm();
        t_inv();
        t_unmapped();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule